// File: doc/BRIEF.md
# One-Time Configuration Fuse Programming Controller

This block is the digital side of a one-time-programmable configuration store. A programmer drives three wires: an active-low chip select, a serial clock and a program data pin. Once the block has been reset, a rising edge of chip select while the data pin is high opens a programming session. The block then takes a 16-bit configuration word, one bit per serial clock rising edge. It waits for a high-voltage indication and counts 16 burn clocks. When the last burn clock arrives it writes the word into a fuse image.

The fuse image is not reset and models non-volatile storage. It reads all zeros until it is burned, and it can be burned only once. The active configuration is a separate register. It copies the fuse image on reset, and that is the only time it changes. A newly burned word therefore takes effect only after the next reset.

The active configuration is decoded into fields: a rotation direction bit, a 10-bit zero position, a gain select, a reference select, a clamp enable, a 2-bit range code and the angular span that the range code stands for. The block also reports its sequence state and a burn-fault flag. All inputs are sampled on the system clock, and edges are found by comparing each input with its value on the previous cycle.

Top module: `otp_cfg_prog`

## Requirements
- R1: While reset is high, and on the first cycle after it is released, the state output is idle (code 0) and burn_err is 0. The configuration outputs equal the fuse image, which is all zeros before any burn, so the span reads 360.
- R2: In idle, a session opens (state code 1, shifting) only when cs_n rises (low on one cycle, high on the next) while prog_din is 1 and the fuse has not been burned. A cs_n rise while prog_din is 0 leaves the block idle.
- R3: While shifting, each sclk rising edge takes prog_din as one bit. After the 16th bit the state moves to awaiting voltage (code 2).
- R4: The first bit received becomes word bit 15, the direction bit. The next ten bits, MSB first, form the zero position (bits 14:5). Then come gain select (bit 4), reference select (bit 3), clamp enable (bit 2) and the range code (bits 1:0, high bit first).
- R5: While the block awaits voltage, sclk edges are ignored and shift in no further data. The block enters burning (code 3) on the cycle after vprog_present is seen high.
- R6: While burning, each sclk rising edge with vprog_present high counts as one burn clock. The 16th burn clock commits the shifted word to the fuse image, moves the state to done (code 4) and sets programmed to 1.
- R7: If vprog_present is low during burning, the state moves to error (code 5) and burn_err becomes 1. The fuse image is not written, so programmed stays 0 and the configuration after reset is unchanged.
- R8: Only reset leaves a session. Chip select edges have no effect while shifting, in done or in error.
- R9: The configuration outputs change only while reset is high. A word burned during a session appears on them only after the next reset.
- R10: Once programmed is 1, a chip select rise with prog_din high is refused and the block stays idle.
- R11: The span output decodes the range code: 00 gives 360, 01 gives 180, 10 gives 90 and 11 gives 45.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset; stands in for power-on |
| cs_n | input | 1 | Active-low chip select; its rising edge opens a session |
| sclk | input | 1 | Serial clock; rising edges shift data or count burn clocks |
| prog_din | input | 1 | Program data pin |
| vprog_present | input | 1 | High while the programming voltage is applied |
| cfg_ccw | output | 1 | Direction bit: 1 means the angle grows with counterclockwise rotation |
| cfg_zero | output | 10 | Zero position |
| cfg_gain_int | output | 1 | Amplifier gain select: 1 internal, 0 external |
| cfg_ref_ext | output | 1 | Converter reference select: 1 external, 0 internal |
| cfg_clamp | output | 1 | Output span clamp enable |
| cfg_range | output | 2 | Range code |
| cfg_span_deg | output | 9 | Span in degrees decoded from the range code |
| prog_state | output | 3 | 0 idle, 1 shifting, 2 awaiting voltage, 3 burning, 4 done, 5 error |
| burn_err | output | 1 | Voltage was lost during the burn |
| programmed | output | 1 | The fuse image has been burned |

## Verification
The bench builds the block with its default burn length of 16. The shift counter and the burn counter therefore both reach their terminal value on the same count, and every field position of the full 16-bit word can be seen at the outputs. The first session has its voltage removed after five burn clocks. The second session runs to completion with extra serial clocks in the waiting phase. Because the fuse image is not reset, one run covers the failed burn, the successful burn, the delayed activation and the refusal of a second session. Only one range code can be committed per run, so the span decode is observed for that code and for the unprogrammed zero code.

// File: rtl/otp_pkg.sv
package otp_pkg;

  localparam int CFG_W  = 16;
  localparam int ZERO_W = 10;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_SHIFT = 3'd1,
    ST_AWAIT = 3'd2,
    ST_BURN  = 3'd3,
    ST_DONE  = 3'd4,
    ST_FAULT = 3'd5
  } prog_state_e;

  typedef struct packed {
    logic              ccw;
    logic [ZERO_W-1:0] zero;
    logic              gain_int;
    logic              ref_ext;
    logic              clamp;
    logic [1:0]        range;
  } cfg_word_t;

  function automatic logic [8:0] span_of(input logic [1:0] code);
    span_of = 9'd360 >> code;
  endfunction

endpackage

// File: rtl/otp_edge_det.sv
module otp_edge_det #(
  parameter int          N       = 2,
  parameter logic [31:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] sig,
  output logic [N-1:0] rise
);

  logic [N-1:0] prev_q;

  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst) prev_q[i] <= RST_VAL[i];
      else     prev_q[i] <= sig[i];
    end
    assign rise[i] = sig[i] & ~prev_q[i];
  end

endmodule

// File: rtl/otp_shifter.sv
module otp_shifter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic         din,
  output logic [W-1:0] word
);

  always_ff @(posedge clk) begin
    if (rst)     word <= '0;
    else if (en) word <= {word[W-2:0], din};
  end

endmodule

// File: rtl/otp_seq.sv
module otp_seq
  import otp_pkg::*;
#(
  parameter int W    = 16,
  parameter int BURN = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cs_rise,
  input  logic         sclk_rise,
  input  logic         din,
  input  logic         vprog,
  input  logic [W-1:0] shift_word,
  output logic         shift_en,
  output prog_state_e  state,
  output logic         burn_err,
  output logic         burned,
  output logic [W-1:0] fuse
);

  localparam int MAXC = (W > BURN) ? W : BURN;
  localparam int CW   = $clog2(MAXC + 1);

  logic [CW-1:0] cnt;
  logic          last_bit, last_burn, commit;

  assign last_bit  = (cnt == CW'(W - 1));
  assign last_burn = (cnt == CW'(BURN - 1));
  assign shift_en  = (state == ST_SHIFT) && sclk_rise;
  assign commit    = (state == ST_BURN) && vprog && sclk_rise && last_burn;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      burn_err <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (cs_rise && din && !burned) begin
            state <= ST_SHIFT;
            cnt   <= '0;
          end
        end
        ST_SHIFT: begin
          if (sclk_rise) begin
            if (last_bit) begin
              state <= ST_AWAIT;
              cnt   <= '0;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        ST_AWAIT: begin
          if (vprog) begin
            state <= ST_BURN;
            cnt   <= '0;
          end
        end
        ST_BURN: begin
          if (!vprog) begin
            state    <= ST_FAULT;
            burn_err <= 1'b1;
          end else if (sclk_rise) begin
            if (last_burn) state <= ST_DONE;
            else           cnt   <= cnt + 1'b1;
          end
        end
        default: state <= state;
      endcase
    end
  end

  // Non-volatile image: untouched by reset.
  logic [W-1:0] fuse_q   = '0;
  logic         burned_q = 1'b0;

  always_ff @(posedge clk) begin
    if (!rst && commit) begin
      fuse_q   <= shift_word;
      burned_q <= 1'b1;
    end
  end

  assign fuse   = fuse_q;
  assign burned = burned_q;

  // R5: waiting phase holds while no voltage is present
  p_await_holds_r5: assert property (@(posedge clk) disable iff (rst)
    (state == ST_AWAIT && !vprog) |=> (state == ST_AWAIT));

  // R7: losing voltage during burn faults the session
  p_vprog_loss_r7: assert property (@(posedge clk) disable iff (rst)
    (state == ST_BURN && !vprog) |=> (state == ST_FAULT && burn_err && !burned));

  // R8: end states are sticky until reset
  p_sticky_end_r8: assert property (@(posedge clk) disable iff (rst)
    (state == ST_DONE || state == ST_FAULT) |=> $stable(state));

  // R10: a burned part never reopens a session
  p_refuse_r10: assert property (@(posedge clk) disable iff (rst)
    (burned && state == ST_IDLE) |=> (state == ST_IDLE));

  // R6: the programmed flag rises only together with the done state
  p_commit_done_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(burned) |-> (state == ST_DONE));

  // R3: counter restarts when the word is complete
  p_count_clear_r3: assert property (@(posedge clk) disable iff (rst)
    (state == ST_AWAIT) |-> (cnt == '0));

endmodule

// File: rtl/otp_cfg_prog.sv
module otp_cfg_prog
  import otp_pkg::*;
#(
  parameter int BURN_CLKS = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic              prog_din,
  input  logic              vprog_present,
  output logic              cfg_ccw,
  output logic [ZERO_W-1:0] cfg_zero,
  output logic              cfg_gain_int,
  output logic              cfg_ref_ext,
  output logic              cfg_clamp,
  output logic [1:0]        cfg_range,
  output logic [8:0]        cfg_span_deg,
  output logic [2:0]        prog_state,
  output logic              burn_err,
  output logic              programmed
);

  logic [1:0]       rise;
  logic             shift_en;
  logic [CFG_W-1:0] shift_word, fuse_word;
  prog_state_e      st;
  cfg_word_t        active_q;
  logic [8:0]       span_q;

  otp_edge_det #(.N(2), .RST_VAL(32'h3)) u_edge (
    .clk (clk),
    .rst (rst),
    .sig ({sclk, cs_n}),
    .rise(rise)
  );

  otp_shifter #(.W(CFG_W)) u_shift (
    .clk (clk),
    .rst (rst),
    .en  (shift_en),
    .din (prog_din),
    .word(shift_word)
  );

  otp_seq #(.W(CFG_W), .BURN(BURN_CLKS)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .cs_rise   (rise[0]),
    .sclk_rise (rise[1]),
    .din       (prog_din),
    .vprog     (vprog_present),
    .shift_word(shift_word),
    .shift_en  (shift_en),
    .state     (st),
    .burn_err  (burn_err),
    .burned    (programmed),
    .fuse      (fuse_word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= cfg_word_t'(fuse_word);
      span_q   <= span_of(fuse_word[1:0]);
    end
  end

  assign cfg_ccw      = active_q.ccw;
  assign cfg_zero     = active_q.zero;
  assign cfg_gain_int = active_q.gain_int;
  assign cfg_ref_ext  = active_q.ref_ext;
  assign cfg_clamp    = active_q.clamp;
  assign cfg_range    = active_q.range;
  assign cfg_span_deg = span_q;
  assign prog_state   = st;

  logic rst_d = 1'b1;
  always_ff @(posedge clk) rst_d <= rst;

  // R9: active configuration is frozen outside reset
  p_cfg_hold_r9: assert property (@(posedge clk) disable iff (rst || rst_d)
    $stable(active_q) && $stable(span_q));

endmodule

// File: tb/sim_otp_cfg_prog.sv
module sim_otp_cfg_prog;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_n = 1'b1, sclk = 1'b0, prog_din = 1'b0, vprog_present = 1'b0;
  logic       cfg_ccw, cfg_gain_int, cfg_ref_ext, cfg_clamp, burn_err, programmed;
  logic [9:0] cfg_zero;
  logic [1:0] cfg_range;
  logic [8:0] cfg_span_deg;
  logic [2:0] prog_state;

  always #10 clk = ~clk;

  otp_cfg_prog u0 (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk), .prog_din(prog_din),
    .vprog_present(vprog_present), .cfg_ccw(cfg_ccw), .cfg_zero(cfg_zero),
    .cfg_gain_int(cfg_gain_int), .cfg_ref_ext(cfg_ref_ext), .cfg_clamp(cfg_clamp),
    .cfg_range(cfg_range), .cfg_span_deg(cfg_span_deg), .prog_state(prog_state),
    .burn_err(burn_err), .programmed(programmed)
  );

  int n_cmp = 0, n_bad = 0, cyc = 0;
  string cur_req = "R1";
  bit chk_on = 0;

  // behavioural reference
  int         m_st = 0, m_n = 0;
  bit         m_pcs = 1, m_psc = 1, m_burned = 0;
  bit         m_q[$];
  logic [15:0] m_fuse = '0, m_act = '0;

  always @(posedge clk) begin
    if (rst) begin
      m_st = 0; m_pcs = 1; m_psc = 1; m_act = m_fuse; m_n = 0;
    end else begin
      bit cr, sr;
      cr = cs_n && !m_pcs;
      sr = sclk && !m_psc;
      case (m_st)
        0: if (cr && prog_din && !m_burned) begin m_st = 1; m_q.delete(); end
        1: if (sr) begin m_q.push_back(prog_din); if (m_q.size() == 16) m_st = 2; end
        2: if (vprog_present) begin m_st = 3; m_n = 0; end
        3: if (!vprog_present) m_st = 5;
           else if (sr) begin
             m_n++;
             if (m_n == 16) begin
               m_st = 4; m_burned = 1;
               for (int k = 0; k < 16; k++) m_fuse[15-k] = m_q[k];
             end
           end
        default: ;
      endcase
      m_pcs = cs_n; m_psc = sclk;
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp, string what);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (chk_on) begin
      chk(cur_req, 32'(prog_state), 32'(m_st), "state");
      chk(cur_req, 32'(burn_err), 32'(m_st == 5), "burn_err");
      chk(cur_req, 32'(programmed), 32'(m_burned), "programmed");
      chk(cur_req, 32'({cfg_ccw, cfg_zero, cfg_gain_int, cfg_ref_ext, cfg_clamp, cfg_range}),
          32'(m_act), "cfg");
      chk(cur_req, 32'(cfg_span_deg), 32'(360 >> m_act[1:0]), "span");
    end
  end

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d expected below 20000 cycles", cyc);
      summary();
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(bit d);
    @(negedge clk); prog_din = d; sclk = 1'b1;
    @(negedge clk); sclk = 1'b0;
  endtask

  task automatic cs_edge(bit d);
    @(negedge clk); cs_n = 1'b0; prog_din = d;
    @(negedge clk); cs_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    idle(3);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic shift_word(logic [15:0] w, bit poke_cs);
    for (int i = 15; i >= 0; i--) begin
      pulse(w[i]);
      if (poke_cs && i == 8) begin
        cur_req = "R8";
        cs_edge(1'b1);
        chk("R8", 32'(prog_state), 32'd1, "cs edge while shifting");
        cur_req = "R3";
      end
    end
  endtask

  localparam logic [15:0] W1 = 16'hA5C3;
  localparam logic [15:0] W2 = 16'hD9D6;

  initial begin
    idle(3);
    chk_on = 1;
    rst = 1'b0;
    @(negedge clk);
    cur_req = "R1";
    chk("R1", 32'(prog_state), 32'd0, "reset state");
    chk("R1", 32'(cfg_span_deg), 32'd360, "unprogrammed span");
    chk("R1", 32'(cfg_zero), 32'd0, "unprogrammed zero");

    cur_req = "R2";
    cs_edge(1'b0);
    chk("R2", 32'(prog_state), 32'd0, "entry with pin low");
    idle(2);
    cs_edge(1'b1);
    chk("R2", 32'(prog_state), 32'd1, "entry with pin high");

    cur_req = "R3";
    shift_word(W1, 1'b1);
    idle(1);
    chk("R3", 32'(prog_state), 32'd2, "await after 16 bits");

    cur_req = "R5";
    pulse(1'b1); pulse(1'b0);
    chk("R5", 32'(prog_state), 32'd2, "sclk ignored while awaiting");

    cur_req = "R7";
    @(negedge clk); vprog_present = 1'b1;
    idle(1);
    chk("R5", 32'(prog_state), 32'd3, "burn entered");
    repeat (5) pulse(1'b1);
    @(negedge clk); vprog_present = 1'b0;
    idle(1);
    chk("R7", 32'(prog_state), 32'd5, "fault after voltage loss");
    chk("R7", 32'(burn_err), 32'd1, "burn_err set");
    cur_req = "R8";
    cs_edge(1'b1);
    chk("R8", 32'(prog_state), 32'd5, "fault sticky");

    cur_req = "R7";
    do_reset();
    chk("R7", 32'(programmed), 32'd0, "no commit after fault");
    chk("R7", 32'(cfg_zero), 32'd0, "cfg unchanged after fault");

    cur_req = "R6";
    cs_edge(1'b1);
    shift_word(W2, 1'b0);
    cur_req = "R5";
    pulse(1'b0); pulse(1'b1); pulse(1'b1);
    @(negedge clk); vprog_present = 1'b1;
    cur_req = "R6";
    idle(1);
    repeat (15) pulse(1'b1);
    chk("R6", 32'(prog_state), 32'd3, "still burning after 15");
    pulse(1'b1);
    chk("R6", 32'(prog_state), 32'd4, "done after 16");
    chk("R6", 32'(programmed), 32'd1, "programmed set");
    chk("R9", 32'(cfg_zero), 32'd0, "cfg not yet active");
    @(negedge clk); vprog_present = 1'b0;
    cur_req = "R8";
    cs_edge(1'b1);
    chk("R8", 32'(prog_state), 32'd4, "done sticky");

    cur_req = "R9";
    do_reset();
    chk("R4", 32'(cfg_ccw), 32'(W2[15]), "direction bit");
    chk("R4", 32'(cfg_zero), 32'(W2[14:5]), "zero position");
    chk("R4", 32'({cfg_gain_int, cfg_ref_ext, cfg_clamp}), 32'(W2[4:2]), "mode bits");
    chk("R4", 32'(cfg_range), 32'(W2[1:0]), "range code");
    chk("R11", 32'(cfg_span_deg), 32'd90, "span for code 10");
    chk("R9", 32'({cfg_ccw, cfg_zero, cfg_gain_int, cfg_ref_ext, cfg_clamp, cfg_range}),
        32'(W2), "word active after reset");

    cur_req = "R10";
    cs_edge(1'b1);
    idle(2);
    chk("R10", 32'(prog_state), 32'd0, "second session refused");

    idle(2);
    summary();
  end

endmodule